// File: doc/BRIEF.md
# Multichannel Scan Sequencer with Multiplexer Strobe

This block steps a converter through a programmed list of logical slots, up to eight of them. Each slot has three phases. The first is a settling phase, in which a break-before-make strobe is held high so that an external multiplexer can switch while the modulator and filter are held in reset. The second is a conversion phase, which ends when the converter reports that the conversion is done. The third is a calibration phase, which ends when the calibration-done input is seen. After that the sequencer moves on to the next slot. After the last programmed slot it returns to slot 0.

Software fills a small register file through a write port. Each slot entry holds:
- the physical input to select,
- a 2-bit gain code,
- a bipolar flag.

A scan-length register sets how many slots are visited. When a slot starts, its settings are copied into output registers. They stay fixed until the next slot starts, so the analog path never sees a change in the middle of a conversion.

The length of the settling strobe depends on the noise-reduction mode input. That input is sampled once, at the start of each slot. A free-running divider also produces a one-cycle modulator sample enable at a fixed fraction of the master clock.

Top module: `scan_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer goes to slot 0 in the settling phase. After that edge, `mux_strobe` is 1, `conv_busy` and `cal_busy` are 0, and `chan_addr`, `phys_chan`, `gain_code` and `bipolar` are all 0. Every slot entry and the scan-length register are cleared to 0.
- R2: `mux_strobe` stays high for exactly STROBE_SHORT cycles when `lnr_mode` was 0 at the start of the slot, and for exactly STROBE_LONG cycles when it was 1. The slot starts at the reset edge or at the edge that accepts `cal_done`. A change of `lnr_mode` later in the slot has no effect on that slot.
- R3: Exactly one of `mux_strobe`, `conv_busy` and `cal_busy` is high in every cycle. The phases always run in the order settling, conversion, calibration. The cycle after `cal_done` is accepted is the first settling cycle of the next slot.
- R4: The conversion phase lasts until `conv_done` is seen at a rising edge. The calibration phase lasts until `cal_done` is seen at a rising edge. A done input that arrives in any other phase is ignored.
- R5: `chan_addr` shows the index of the current slot. It changes only in the cycle in which `mux_strobe` rises. Slots are visited in the order 0, 1, … up to the scan length minus 1, and then the sequence returns to 0.
- R6: A write to address NUM_SLOTS (8 by default) stores `wr_data[3:0]` as the scan length. A stored 0 acts as 1, and a value above NUM_SLOTS acts as NUM_SLOTS.
- R7: A write to address i (0 to NUM_SLOTS-1) stores the entry for slot i. The fields are: `wr_data[2:0]` is the physical input, `wr_data[4:3]` is the gain code (0 to 3 selecting gain 1, 2, 4 or 8), and `wr_data[5]` is the bipolar flag. While slot i is active, these fields appear on `phys_chan`, `gain_code` and `bipolar`.
- R8: A register write changes no output within the current slot. It takes effect from the next slot start onward. Writes to addresses above NUM_SLOTS change nothing.
- R9: `sample_en` is a one-cycle pulse every SAMPLE_DIV cycles. Counting from the first cycle after reset as cycle 0, it is high in cycle k exactly when k mod SAMPLE_DIV equals SAMPLE_DIV-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: slot entries 0–7, scan length at 8 |
| wr_data | input | 6 | Write data |
| lnr_mode | input | 1 | Noise-reduction mode; selects the long settling strobe |
| conv_done | input | 1 | Converter reports that the conversion has finished |
| cal_done | input | 1 | Converter reports that the calibration has finished |
| mux_strobe | output | 1 | Break-before-make strobe, high during settling |
| conv_busy | output | 1 | Conversion phase active |
| cal_busy | output | 1 | Calibration phase active |
| chan_addr | output | 3 | Logical index of the active slot |
| phys_chan | output | 3 | Physical input of the active slot |
| gain_code | output | 2 | Gain code of the active slot |
| bipolar | output | 1 | Bipolar flag of the active slot |
| sample_en | output | 1 | Modulator sample enable pulse |

## Verification
The bench sweeps every scan-length value from 0 to 9, including the values that are clamped. For each one it runs twice around the scan, to separate correct wrap-around from an off-by-one error in the slot counter. The slot entries are generated by formula, so a fault in the field packing, in slot indexing or in the slot-start copy shows up as a mismatch on the outputs.

The mode input alternates from slot to slot and is also toggled in the middle of the strobe. This separates start-of-slot sampling of the mode from sampling it continuously. Done pulses are injected in the wrong phase, writes are made in the middle of a slot, and writes are sent to unused addresses. These checks show whether the block ignores input it should not act on. A run with no writes after reset then shows that the register file was cleared.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    localparam int PHYS_W = 3;
    localparam int GAIN_W = 2;

    typedef enum logic [1:0] {
        PH_STROBE = 2'd0,
        PH_CONV   = 2'd1,
        PH_CAL    = 2'd2
    } phase_e;

    // bit 5 bipolar, bits 4:3 gain code, bits 2:0 physical input
    typedef struct packed {
        logic              bipolar;
        logic [GAIN_W-1:0] gain;
        logic [PHYS_W-1:0] phys;
    } slot_cfg_t;

    localparam int CFG_W = $bits(slot_cfg_t);

endpackage

// File: rtl/scan_clkdiv.sv
module scan_clkdiv #(
    parameter  int DIV = 6,
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(DIV - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tick = (st_q.cnt == CW'(DIV - 1));

endmodule

// File: rtl/scan_cfg_regs.sv
module scan_cfg_regs
    import scan_seq_pkg::*;
#(
    parameter  int NUM_SLOTS = 8,
    localparam int AW        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WA_W      = AW + 1,
    localparam int CNT_W     = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WA_W-1:0]  wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_idx,
    output slot_cfg_t        rd_cfg,
    output logic [CNT_W-1:0] scan_len
);

    typedef struct packed {
        slot_cfg_t [NUM_SLOTS-1:0] ent;
        logic [CNT_W-1:0]          len;
    } regs_t;

    regs_t st_d, st_q;
    logic [NUM_SLOTS-1:0] ent_hit;
    logic                 len_hit;

    // one decoder per slot entry
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dec
        assign ent_hit[g] = wr_en && (wr_addr == WA_W'(g));
    end
    assign len_hit = wr_en && (wr_addr == WA_W'(NUM_SLOTS));

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (ent_hit[i]) begin
                st_d.ent[i] = slot_cfg_t'(wr_data);
            end
        end
        if (len_hit) begin
            st_d.len = wr_data[CNT_W-1:0];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // effective length: 0 reads as 1, oversize saturates
    always_comb begin
        if (st_q.len == '0) begin
            scan_len = CNT_W'(1);
        end else if (st_q.len > CNT_W'(NUM_SLOTS)) begin
            scan_len = CNT_W'(NUM_SLOTS);
        end else begin
            scan_len = st_q.len;
        end
    end

    assign rd_cfg = st_q.ent[rd_idx];

endmodule

// File: rtl/scan_phase_fsm.sv
module scan_phase_fsm
    import scan_seq_pkg::*;
#(
    parameter  int NUM_SLOTS    = 8,
    parameter  int STROBE_SHORT = 54,
    parameter  int STROBE_LONG  = 201,
    localparam int AW           = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W        = AW + 1,
    localparam int LMAX         = (STROBE_LONG > STROBE_SHORT) ? STROBE_LONG : STROBE_SHORT,
    localparam int TW           = $clog2(LMAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lnr_mode,
    input  logic             conv_done,
    input  logic             cal_done,
    input  logic [CNT_W-1:0] scan_len,
    input  slot_cfg_t        next_cfg,
    output logic [AW-1:0]    next_slot,
    output phase_e           phase,
    output logic [AW-1:0]    slot,
    output slot_cfg_t        cfg
);

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] slot;
        logic [TW-1:0] tmr;
        slot_cfg_t     cfg;
    } seq_state_t;

    seq_state_t       st_d, st_q;
    logic [CNT_W-1:0] slot_inc;
    logic [TW-1:0]    hold_load;

    always_comb begin
        slot_inc  = {1'b0, st_q.slot} + CNT_W'(1);
        next_slot = (slot_inc >= scan_len) ? '0 : slot_inc[AW-1:0];
        hold_load = lnr_mode ? TW'(STROBE_LONG - 1) : TW'(STROBE_SHORT - 1);
    end

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_STROBE: begin
                if (st_q.tmr == '0) begin
                    st_d.phase = PH_CONV;
                end else begin
                    st_d.tmr = st_q.tmr - 1'b1;
                end
            end
            PH_CONV: begin
                if (conv_done) begin
                    st_d.phase = PH_CAL;
                end
            end
            PH_CAL: begin
                if (cal_done) begin
                    st_d.phase = PH_STROBE;
                    st_d.slot  = next_slot;
                    st_d.tmr   = hold_load;
                    st_d.cfg   = next_cfg;
                end
            end
            default: begin
                st_d.phase = PH_STROBE;
            end
        endcase
        if (rst) begin
            st_d.phase = PH_STROBE;
            st_d.slot  = '0;
            st_d.tmr   = hold_load;
            st_d.cfg   = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase = st_q.phase;
    assign slot  = st_q.slot;
    assign cfg   = st_q.cfg;

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter  int NUM_SLOTS    = 8,
    parameter  int STROBE_SHORT = 54,
    parameter  int STROBE_LONG  = 201,
    parameter  int SAMPLE_DIV   = 6,
    localparam int AW           = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WA_W         = AW + 1,
    localparam int CNT_W        = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic              lnr_mode,
    input  logic              conv_done,
    input  logic              cal_done,
    output logic              mux_strobe,
    output logic              conv_busy,
    output logic              cal_busy,
    output logic [AW-1:0]     chan_addr,
    output logic [PHYS_W-1:0] phys_chan,
    output logic [GAIN_W-1:0] gain_code,
    output logic              bipolar,
    output logic              sample_en
);

    logic [CNT_W-1:0] scan_len;
    logic [AW-1:0]    next_slot;
    slot_cfg_t        next_cfg;
    slot_cfg_t        act_cfg;
    phase_e           phase;

    scan_cfg_regs #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_idx   (next_slot),
        .rd_cfg   (next_cfg),
        .scan_len (scan_len)
    );

    scan_phase_fsm #(
        .NUM_SLOTS    (NUM_SLOTS),
        .STROBE_SHORT (STROBE_SHORT),
        .STROBE_LONG  (STROBE_LONG)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .lnr_mode  (lnr_mode),
        .conv_done (conv_done),
        .cal_done  (cal_done),
        .scan_len  (scan_len),
        .next_cfg  (next_cfg),
        .next_slot (next_slot),
        .phase     (phase),
        .slot      (chan_addr),
        .cfg       (act_cfg)
    );

    scan_clkdiv #(
        .DIV (SAMPLE_DIV)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (sample_en)
    );

    assign mux_strobe = (phase == PH_STROBE);
    assign conv_busy  = (phase == PH_CONV);
    assign cal_busy   = (phase == PH_CAL);
    assign phys_chan  = act_cfg.phys;
    assign gain_code  = act_cfg.gain;
    assign bipolar    = act_cfg.bipolar;

endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk #(
    parameter  int NUM_SLOTS    = 8,
    parameter  int STROBE_SHORT = 54,
    parameter  int STROBE_LONG  = 201,
    parameter  int SAMPLE_DIV   = 6,
    localparam int AW           = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          lnr_mode,
    input logic          conv_done,
    input logic          cal_done,
    input logic          mux_strobe,
    input logic          conv_busy,
    input logic          cal_busy,
    input logic [AW-1:0] chan_addr,
    input logic [2:0]    phys_chan,
    input logic [1:0]    gain_code,
    input logic          bipolar,
    input logic          sample_en
);

    logic [15:0] run_q;
    logic        mode_q;
    logic [15:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            mode_q <= lnr_mode;
            gap_q  <= '0;
        end else begin
            run_q <= mux_strobe ? run_q + 16'd1 : 16'd0;
            if (cal_busy && cal_done) begin
                mode_q <= lnr_mode;
            end
            gap_q <= sample_en ? 16'd0 : gap_q + 16'd1;
        end
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $countones({mux_strobe, conv_busy, cal_busy}) == 1); // R3

    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(mux_strobe) |-> run_q == (mode_q ? 16'(STROBE_LONG) : 16'(STROBE_SHORT))); // R2

    AST_STROBE_TO_CONV: assert property (@(posedge clk) disable iff (rst)
        $fell(mux_strobe) |-> conv_busy); // R3

    AST_CAL_TO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (cal_busy && cal_done) |=> $rose(mux_strobe)); // R3

    AST_CONV_WAIT: assert property (@(posedge clk) disable iff (rst)
        (conv_busy && !conv_done) |=> conv_busy); // R4

    AST_CAL_WAIT: assert property (@(posedge clk) disable iff (rst)
        (cal_busy && !cal_done) |=> cal_busy); // R4

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$rose(mux_strobe) |-> $stable(chan_addr)); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(mux_strobe) |-> (chan_addr == '0 || chan_addr == AW'($past(chan_addr) + 1'b1))); // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$rose(mux_strobe) |-> $stable({phys_chan, gain_code, bipolar})); // R8

    AST_SAMPLE_GAP: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> gap_q == 16'(SAMPLE_DIV - 1)); // R9

endmodule

bind scan_sequencer scan_sequencer_chk #(
    .NUM_SLOTS    (NUM_SLOTS),
    .STROBE_SHORT (STROBE_SHORT),
    .STROBE_LONG  (STROBE_LONG),
    .SAMPLE_DIV   (SAMPLE_DIV)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lnr_mode   (lnr_mode),
    .conv_done  (conv_done),
    .cal_done   (cal_done),
    .mux_strobe (mux_strobe),
    .conv_busy  (conv_busy),
    .cal_busy   (cal_busy),
    .chan_addr  (chan_addr),
    .phys_chan  (phys_chan),
    .gain_code  (gain_code),
    .bipolar    (bipolar),
    .sample_en  (sample_en)
);

// File: tb/scan_sequencer_bench.sv
`timescale 1ns/1ps
module scan_sequencer_bench;

    localparam int NS = 8;
    localparam int SS = 4;
    localparam int SL = 7;
    localparam int DV = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic       lnr = 1'b0;
    logic       cdone = 1'b0;
    logic       kdone = 1'b0;
    logic       mux_strobe, conv_busy, cal_busy, bipolar, sample_en;
    logic [2:0] chan_addr, phys_chan;
    logic [1:0] gain_code;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;
    int  model [NS];

    always #2 clk = ~clk;

    scan_sequencer #(
        .NUM_SLOTS    (NS),
        .STROBE_SHORT (SS),
        .STROBE_LONG  (SL),
        .SAMPLE_DIV   (DV)
    ) u_scan_sequencer (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .lnr_mode   (lnr),
        .conv_done  (cdone),
        .cal_done   (kdone),
        .mux_strobe (mux_strobe),
        .conv_busy  (conv_busy),
        .cal_busy   (cal_busy),
        .chan_addr  (chan_addr),
        .phys_chan  (phys_chan),
        .gain_code  (gain_code),
        .bipolar    (bipolar),
        .sample_en  (sample_en)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int entry_val(int i);
        return (((i >> 1) & 1) << 5) | ((i % 4) << 3) | ((i * 5 + 3) % 8);
    endfunction

    function automatic int cur_cfg();
        return {26'd0, bipolar, gain_code, phys_chan};
    endfunction

    task automatic write_reg(int a, int d);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = 6'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; lnr = 1'b0; cdone = 1'b0; kdone = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NS; i++) model[i] = 0;
        // r1_ reset state
        chk("R1", "strobe", int'(mux_strobe), 1);
        chk("R1", "busy", int'({conv_busy, cal_busy}), 0);
        chk("R1", "addr", int'(chan_addr), 0);
        chk("R1", "cfg", cur_cfg(), 0);
    endtask

    // called at the negedge of the first strobe cycle
    task automatic strobe_phase(int es, int ecfg, int elen, bit toggle, bit cglitch);
        int n = 0;
        while (mux_strobe === 1'b1 && n < 1000) begin
            if (n == 0) begin
                chk("R5", "addr at strobe", int'(chan_addr), es);
                chk("R7", "cfg at strobe", cur_cfg(), ecfg);
            end
            if (n == 1 && toggle) lnr = ~lnr;      // R2 mid-slot mode change
            cdone = (n == 1 && cglitch);           // R4 stray conversion done
            n++;
            @(negedge clk);
        end
        cdone = 1'b0;
        chk("R2", "strobe length", n, elen);
        chk("R3", "conv after strobe", int'(conv_busy), 1);
        chk("R5", "addr in conv", int'(chan_addr), es);
    endtask

    task automatic conv_to_next(bit kglitch, bit next_mode, int es, int ecfg);
        if (kglitch) begin
            kdone = 1'b1;
            @(negedge clk);
            kdone = 1'b0;
            chk("R4", "cal_done ignored in conv", int'({conv_busy, cal_busy}), 2);
        end
        repeat (2) @(negedge clk);
        chk("R4", "conv waits", int'(conv_busy), 1);
        cdone = 1'b1;
        @(negedge clk);
        cdone = 1'b0;
        chk("R3", "cal after conv", int'(cal_busy), 1);
        chk("R8", "cfg held in cal", cur_cfg(), ecfg);
        chk("R5", "addr held in cal", int'(chan_addr), es);
        @(negedge clk);
        chk("R4", "cal waits", int'(cal_busy), 1);
        lnr   = next_mode;
        kdone = 1'b1;
        @(negedge clk);
        kdone = 1'b0;
        chk("R3", "strobe after cal", int'(mux_strobe), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 10; c++) begin
            int ceff;
            ceff = (c == 0) ? 1 : ((c > NS) ? NS : c);
            do_reset();
            strobe_phase(0, 0, SS, 1'b0, 1'b0);
            for (int i = 0; i < NS; i++) begin
                model[i] = entry_val(i + c);
                write_reg(i, model[i]);
            end
            write_reg(NS, c);                      // R6 scan length
            write_reg(12, 6'h3F);                  // R8 unused address
            conv_to_next(1'b0, ((1 + c) % 3) == 0, 0, 0);  // R8 slot 0 keeps reset cfg
            for (int j = 1; j <= 2 * ceff; j++) begin
                int s, ecfg;
                bit m;
                s    = j % ceff;
                ecfg = model[s];
                m    = ((j + c) % 3) == 0;
                strobe_phase(s, ecfg, m ? SL : SS, 1'(j % 2), 1'(j % 2));
                if (c == 5 && j == 2) begin
                    write_reg(s, 6'h2A);           // R8 mid-slot write
                    model[s] = 'h2A;
                end
                conv_to_next(1'((j + 1) % 2), ((j + 1 + c) % 3) == 0, s, ecfg);
            end
        end

        // R9 sample enable cadence, R1 register file cleared
        do_reset();
        for (int k = 0; k < 24; k++) begin
            chk("R9", "sample_en", int'(sample_en), (k % DV) == DV - 1);
            @(negedge clk);
        end
        conv_to_next(1'b0, 1'b0, 0, 0);
        strobe_phase(0, 0, SS, 1'b0, 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule